// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous up-counter built from 4-bit stages. Each stage can be preset from a data input, cleared, held or advanced by one. A parameterised wrapper chains a chosen number of stages into one wide counter. Every stage shares the clock and the run enable. The carry enable enters the lowest stage, and each stage's full flag feeds the carry enable of the stage above it. The result behaves as a single counter of 4 x STAGES bits that wraps from all ones to zero.

Clear, load, count and hold follow a fixed priority. A parameter selects how the clear acts. In one form it takes effect at the next rising clock edge. In the other it zeroes the count at once, without waiting for the clock. The full flag is combinational. It is high only while the whole count is all ones and the carry enable is high. Several wrappers can therefore be chained in turn through the carry enable.

Top module: `bincnt_chain`

## Requirements
- R1: When counting, the count advances by one modulo 2^(4 x STAGES) per rising edge; from all ones it goes to zero.
- R2: With ASYNC_CLR=1, clear_n low forces count to zero at once, before any clock edge, and keeps it there while low.
- R3: With ASYNC_CLR=0, clear_n low leaves the count unchanged until the next rising edge, which sets it to zero; clear wins over load_n low and over the count enables.
- R4: With clear_n high, load_n low copies load_val into count on the next rising edge, regardless of run_en and carry_en.
- R5: With clear_n and load_n high, the count increments on a rising edge only when run_en and carry_en are both high.
- R6: With clear_n and load_n high, the count holds its value if run_en or carry_en is low.
- R7: full_out is 1 exactly when count is all ones and carry_en is 1; run_en and load_n do not affect it, and a change of carry_en shows on full_out within the same cycle.
- R8: Each stage's full flag gates the stage above, so a carry out of the low 4 bits advances the upper bits on the same edge (for example 0x0F to 0x10, 0xFF to 0x00).
- R9: After a clear, count is zero and full_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear, synchronous or asynchronous by ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load enable |
| load_val | input | 4*STAGES | Value loaded into the count |
| run_en | input | 1 | Count enable shared by all stages |
| carry_en | input | 1 | Count enable into the lowest stage, also gates full_out |
| count | output | 4*STAGES | Current count |
| full_out | output | 1 | Terminal flag: count all ones and carry_en high |

## Verification
The hardest situation to reach is the carry between stages combined with the gating of the full flag. The count must sit at all ones while carry_en, run_en and load_n change separately. The stimulus loads values just below a stage boundary and then toggles each enable alone at that boundary. A free-running stretch longer than one full period covers the wrap. Both clear variants run side by side. Clear is changed in the middle of a cycle, so the bench can tell an immediate clear from one that waits for the edge.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
   // Operating mode of one stage, listed from lowest to highest priority
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } cnt_mode_e;

   localparam int unsigned DEF_STAGE_W = 4;
   localparam int unsigned DEF_STAGES  = 2;
endpackage

// File: rtl/bincnt_mode_sel.sv
module bincnt_mode_sel
   import bincnt_pkg::*;
(
   input  logic      clear_n,
   input  logic      load_n,
   input  logic      run_en,
   input  logic      carry_en,
   output cnt_mode_e mode
);
   // Fixed priority: clear, then load, then count, then hold
   always_comb begin
      if (!clear_n)                mode = MODE_CLEAR;
      else if (!load_n)            mode = MODE_LOAD;
      else if (run_en && carry_en) mode = MODE_COUNT;
      else                         mode = MODE_HOLD;
   end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
   import bincnt_pkg::*;
#(
   parameter int unsigned STAGE_W   = DEF_STAGE_W,
   parameter bit          ASYNC_CLR = 1'b0
) (
   input  logic               clk,
   input  logic               clear_n,
   input  logic               load_n,
   input  logic [STAGE_W-1:0] load_val,
   input  logic               run_en,
   input  logic               carry_en,
   output logic [STAGE_W-1:0] q,
   output logic               full
);
   localparam logic [STAGE_W-1:0] ALL_ONES = {STAGE_W{1'b1}};
   localparam logic [STAGE_W-1:0] STEP     = STAGE_W'(1);

   if (STAGE_W < 1) begin : g_bad_w
      $error("bincnt_stage: STAGE_W must be at least 1");
   end

   cnt_mode_e          mode;
   logic [STAGE_W-1:0] q_nxt;

   bincnt_mode_sel u_sel (
      .clear_n  (clear_n),
      .load_n   (load_n),
      .run_en   (run_en),
      .carry_en (carry_en),
      .mode     (mode)
   );

   always_comb begin
      unique case (mode)
         MODE_CLEAR: q_nxt = '0;
         MODE_LOAD:  q_nxt = load_val;
         MODE_COUNT: q_nxt = q + STEP;
         default:    q_nxt = q;
      endcase
   end

   if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clear_n) begin
         if (!clear_n) q <= '0;
         else          q <= q_nxt;
      end
   end else begin : g_sync_clr
      always_ff @(posedge clk) begin
         q <= q_nxt;
      end
   end

   // Only the carry enable gates the flag
   assign full = (q == ALL_ONES) && carry_en;
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain
   import bincnt_pkg::*;
#(
   parameter int unsigned STAGES    = DEF_STAGES,
   parameter int unsigned STAGE_W   = DEF_STAGE_W,
   parameter bit          ASYNC_CLR = 1'b0,
   localparam int unsigned TOT_W    = STAGES * STAGE_W
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load_n,
   input  logic [TOT_W-1:0] load_val,
   input  logic             run_en,
   input  logic             carry_en,
   output logic [TOT_W-1:0] count,
   output logic             full_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("bincnt_chain: STAGES must be at least 1");
   end

   // link[i] is the carry enable of stage i; link[STAGES] is the top flag
   logic [STAGES:0] link;
   assign link[0] = carry_en;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      bincnt_stage #(
         .STAGE_W   (STAGE_W),
         .ASYNC_CLR (ASYNC_CLR)
      ) u_stage (
         .clk      (clk),
         .clear_n  (clear_n),
         .load_n   (load_n),
         .load_val (load_val[i*STAGE_W +: STAGE_W]),
         .run_en   (run_en),
         .carry_en (link[i]),
         .q        (count[i*STAGE_W +: STAGE_W]),
         .full     (link[i+1])
      );
   end

   assign full_out = link[STAGES];
endmodule

// File: rtl/bincnt_chain_chk.sv
module bincnt_chain_chk #(
   parameter int unsigned STAGES    = 2,
   parameter int unsigned STAGE_W   = 4,
   parameter bit          ASYNC_CLR = 1'b0,
   localparam int unsigned TOT_W    = STAGES * STAGE_W
) (
   input logic             clk,
   input logic             clear_n,
   input logic             load_n,
   input logic [TOT_W-1:0] load_val,
   input logic             run_en,
   input logic             carry_en,
   input logic [TOT_W-1:0] count,
   input logic             full_out
);
   localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!clear_n)
      !load_n |=> count == $past(load_val)); // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
      (load_n && run_en && carry_en) |=> count == $past(count) + ONE); // R5

   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!clear_n)
      (load_n && !(run_en && carry_en)) |=> $stable(count)); // R6

   AST_FULL_GATE: assert property (@(posedge clk) disable iff (!clear_n)
      full_out == ((&count) && carry_en)); // R7

   if (ASYNC_CLR) begin : g_async
      AST_CLEAR_NOW: assert property (@(posedge clk)
         !clear_n |-> (count == '0 && !full_out)); // R2
   end else begin : g_sync
      AST_CLEAR_EDGE: assert property (@(posedge clk)
         !clear_n |=> count == '0); // R3
   end
endmodule

bind bincnt_chain bincnt_chain_chk #(
   .STAGES    (STAGES),
   .STAGE_W   (STAGE_W),
   .ASYNC_CLR (ASYNC_CLR)
) u_chk (
   .clk      (clk),
   .clear_n  (clear_n),
   .load_n   (load_n),
   .load_val (load_val),
   .run_en   (run_en),
   .carry_en (carry_en),
   .count    (count),
   .full_out (full_out)
);

// File: tb/bincnt_chain_tb.sv
module bincnt_chain_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clear_n = 1'b0;
   logic         load_n = 1'b1;
   logic [W-1:0] load_val = '0;
   logic         run_en = 1'b0;
   logic         carry_en = 1'b0;
   logic [W-1:0] cnt_s, cnt_a;
   logic         full_s, full_a;

   int n_checks = 0;
   int n_fail = 0;
   int m_s = 0;
   int m_a = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bincnt_chain #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b0)) u_dut (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .load_val(load_val),
      .run_en(run_en), .carry_en(carry_en), .count(cnt_s), .full_out(full_s));

   bincnt_chain #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b1)) u_dut_async (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .load_val(load_val),
      .run_en(run_en), .carry_en(carry_en), .count(cnt_a), .full_out(full_a));

   function automatic int next_val(int cur, bit c, bit l, int d, bit ep, bit et);
      if (!c)            return 0;
      else if (!l)       return d;
      else if (ep && et) return (cur + 1) % 256;
      else               return cur;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check mid-cycle, update the model at posedge
   task automatic cycle(bit c, bit l, int d, bit ep, bit et, string tag);
      int exp_full_s, exp_full_a;
      @(negedge clk);
      clear_n = c; load_n = l; load_val = W'(d); run_en = ep; carry_en = et;
      if (!c) m_a = 0;
      #1;
      check(int'(cnt_s) == m_s, {tag, " sync count"}, int'(cnt_s), m_s);
      check(int'(cnt_a) == m_a, {tag, " async count"}, int'(cnt_a), m_a);
      exp_full_s = (m_s == 255 && et) ? 1 : 0;
      exp_full_a = (m_a == 255 && et) ? 1 : 0;
      check(int'(full_s) == exp_full_s, "R7 sync full", int'(full_s), exp_full_s);
      check(int'(full_a) == exp_full_a, "R7 async full", int'(full_a), exp_full_a);
      @(posedge clk);
      m_s = next_val(m_s, c, l, d, ep, et);
      m_a = next_val(m_a, c, l, d, ep, et);
   endtask

   initial begin
      // R9: clear from time zero
      m_s = 0; m_a = 0;
      @(posedge clk);
      cycle(0, 1, 0, 0, 0, "R9");
      cycle(1, 1, 0, 0, 0, "R9");
      // R4: load, then load while counting is enabled
      cycle(1, 0, 8'h3C, 0, 0, "R4");
      cycle(1, 0, 8'hA5, 1, 1, "R4");
      // R3: clear and load together, clear wins
      cycle(0, 0, 8'h77, 1, 1, "R3");
      cycle(1, 0, 8'h0E, 1, 1, "R3");
      // R5 and R8: count across the stage boundary 0x0F to 0x10
      for (int i = 0; i < 4; i++) cycle(1, 1, 0, 1, 1, "R8");
      // R6: hold with either enable low
      cycle(1, 1, 0, 0, 1, "R6");
      cycle(1, 1, 0, 1, 0, "R6");
      cycle(1, 1, 0, 0, 0, "R6");
      // R7: at all ones, vary each input alone
      cycle(1, 0, 8'hFF, 0, 0, "R7");
      cycle(1, 1, 0, 0, 1, "R7");
      cycle(1, 1, 0, 0, 0, "R7");
      cycle(1, 0, 8'h12, 1, 1, "R7");
      cycle(1, 0, 8'hFF, 1, 0, "R7");
      cycle(1, 1, 0, 1, 1, "R1");
      cycle(1, 1, 0, 1, 1, "R1");
      // R2 versus R3: clear arriving mid-cycle from a nonzero value
      cycle(1, 0, 8'h5A, 0, 0, "R4");
      cycle(0, 1, 0, 1, 1, "R2");
      cycle(1, 1, 0, 1, 1, "R3");
      // R1: free run over a full period
      for (int i = 0; i < 300; i++) cycle(1, 1, 0, 1, 1, "R1");
      // R5/R6: mixed stimulus
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom);
         cycle((r % 23) != 0, (r % 11) != 0, (r >> 8) & 255,
               ((r >> 16) & 3) != 0, ((r >> 18) & 3) != 0, "R5");
      end
      cycle(1, 1, 0, 0, 0, "R6");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule